// File: doc/BRIEF.md
# Block Transfer Engine with Bus Hand-Off

This block copies a run of words between one peripheral and memory without the processor moving any data. While the processor owns the system bus, it programs three registers through a small register port: a start address, a word count, and a control register that sets the direction and starts the transfer. The register port has a chip select, a register select, read and write strobes and a data bus.

Once started, the block raises a bus request whenever the peripheral asks for service and words remain to move. While the grant input is high, the block owns the memory side. Each cycle with grant and peripheral request both high moves one word: the block drives the address, the memory read or write strobe and the peripheral acknowledge. The address then steps up and the count steps down. When the count reaches zero, the block drops its request, sets a done flag and raises its interrupt. If grant is taken away in the middle of a transfer, the block waits with its state intact.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, the address and count registers read 0, and the control register reads 0. bus_req_o, dack_o, done_o and irq_o are low.
- R2: While bus_grant_i is low and cs_i is high, a write strobe loads the register picked by reg_sel_i on the next clock edge. The selections are 0 = address, 1 = count, 2 = control. A read strobe returns that register on cpu_rdata_o in the same cycle. Selection 3 reads 0. A control write uses bit 0 for start and bit 1 for direction (0 = peripheral to memory, 1 = memory to peripheral). A control read returns run in bit 0, direction in bit 1 and done in bit 2.
- R3: While bus_grant_i is high, processor register writes change nothing and cpu_rdata_o stays 0.
- R4: bus_req_o is high exactly when a transfer is running, drq_i is high and the count is nonzero. No word moves while drq_i is low.
- R5: A word moves in any cycle where bus_req_o and bus_grant_i are both high. In that cycle dack_o is high and mem_addr_o equals the address register. With direction 0, mem_wr_o is high and mem_wdata_o equals per_data_i. With direction 1, mem_rd_o is high and per_data_o equals mem_rdata_i. In all other cycles dack_o, mem_rd_o and mem_wr_o are low.
- R6: After each word moves, the address is one higher and the count one lower, starting from the next clock edge.
- R7: When the last word moves, from the next edge onward done_o and irq_o are high, run is low and bus_req_o is low.
- R8: While grant is low during a running transfer, the address and count hold their values and the transfer resumes when grant returns.
- R9: A control write with start set clears done_o and irq_o on the next edge.
- R10: Starting with a count of zero sets done_o on the next edge without ever raising bus_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register port chip select |
| reg_sel_i | input | 2 | Register select |
| cpu_rd_i | input | 1 | Register read strobe |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_wdata_i | input | DATA_W | Register write data |
| cpu_rdata_o | output | DATA_W | Register read data |
| bus_req_o | output | 1 | Bus request to the processor |
| bus_grant_i | input | 1 | Bus grant from the processor |
| mem_addr_o | output | ADDR_W | Memory address during a word move |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DATA_W | Data written to memory |
| mem_rdata_i | input | DATA_W | Data read from memory |
| drq_i | input | 1 | Peripheral service request |
| dack_o | output | 1 | Peripheral acknowledge |
| per_data_i | input | DATA_W | Data from the peripheral |
| per_data_o | output | DATA_W | Data to the peripheral |
| done_o | output | 1 | Transfer finished flag |
| irq_o | output | 1 | Completion interrupt |

## Verification
Read data, bus request, acknowledge, strobes and the memory address are combinational with no register on the path. The bench checks them one time step after it drives the inputs, in the same cycle and well before the next edge. Register loads, address and count steps, done and run take effect at the first clock edge after the stimulus. The bench therefore checks them one time step after that edge, either at the ports or through a processor read-back with grant low. Each word move is limited to one edge by removing drq_i or bus_grant_i before the following edge.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_RSVD  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    DIR_TO_MEM = 1'b0,
    DIR_TO_PER = 1'b1
  } dir_e;

  localparam int CTL_START_BIT = 0;
  localparam int CTL_DIR_BIT   = 1;
  localparam int STS_RUN_BIT   = 0;
  localparam int STS_DIR_BIT   = 1;
  localparam int STS_DONE_BIT  = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_addr_i,
  input  logic              ld_cnt_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_zero_o,
  output logic              cnt_last_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (ld_addr_i) begin
      addr_q <= ADDR_W'(wdata_i);
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_cnt_i) begin
      cnt_q <= CNT_W'(wdata_i);
    end else if (step_i) begin
      cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign addr_o     = addr_q;
  assign cnt_o      = cnt_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_last_o = (cnt_q == CNT_ONE);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_wr_i,
  input  logic start_i,
  input  logic dir_i,
  input  logic grant_i,
  input  logic drq_i,
  input  logic cnt_zero_i,
  input  logic cnt_last_i,
  output logic run_o,
  output logic done_o,
  output dir_e dir_o,
  output logic bus_req_o,
  output logic beat_o
);
  logic run_q;
  logic done_q;
  dir_e dir_q;

  assign bus_req_o = run_q && drq_i && !cnt_zero_i;
  assign beat_o    = bus_req_o && grant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= DIR_TO_MEM;
    end else if (ctl_wr_i) begin
      dir_q <= dir_e'(dir_i);
      if (start_i) begin
        // zero-length job finishes immediately
        run_q  <= !cnt_zero_i;
        done_q <= cnt_zero_i;
      end
    end else if (beat_o && cnt_last_i) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign run_o  = run_q;
  assign done_o = done_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/dma_xfer_mux.sv
module dma_xfer_mux
  import dma_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              beat_i,
  input  dir_e              dir_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] per_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] per_data_o,
  output logic              dack_o
);
  logic to_mem;
  logic to_per;

  assign to_mem = beat_i && (dir_i == DIR_TO_MEM);
  assign to_per = beat_i && (dir_i == DIR_TO_PER);

  assign dack_o      = beat_i;
  assign mem_addr_o  = beat_i ? addr_i : '0;
  assign mem_wr_o    = to_mem;
  assign mem_rd_o    = to_per;
  assign mem_wdata_o = to_mem ? per_data_i : '0;
  assign per_data_o  = to_per ? mem_rdata_i : '0;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_grant_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              drq_i,
  output logic              dack_o,
  input  logic [DATA_W-1:0] per_data_i,
  output logic [DATA_W-1:0] per_data_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam int STS_W = STS_DONE_BIT + 1;

  reg_sel_e          sel;
  logic              cpu_acc;
  logic              wr_en;
  logic              rd_en;
  logic              ld_addr;
  logic              ld_cnt;
  logic              ctl_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_zero;
  logic              cnt_last;
  logic              run;
  logic              done;
  dir_e              dir;
  logic              beat;
  logic [STS_W-1:0]  status;
  logic [DATA_W-1:0] rd_mux;

  // register port is live only while the processor owns the bus
  assign sel     = reg_sel_e'(reg_sel_i);
  assign cpu_acc = cs_i && !bus_grant_i;
  assign wr_en   = cpu_acc && cpu_wr_i;
  assign rd_en   = cpu_acc && cpu_rd_i;
  assign ld_addr = wr_en && (sel == SEL_ADDR);
  assign ld_cnt  = wr_en && (sel == SEL_COUNT);
  assign ctl_wr  = wr_en && (sel == SEL_CTRL);

  dma_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_addr_i  (ld_addr),
    .ld_cnt_i   (ld_cnt),
    .wdata_i    (cpu_wdata_i),
    .step_i     (beat),
    .addr_o     (addr_q),
    .cnt_o      (cnt_q),
    .cnt_zero_o (cnt_zero),
    .cnt_last_o (cnt_last)
  );

  dma_engine u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_wr_i   (ctl_wr),
    .start_i    (cpu_wdata_i[CTL_START_BIT]),
    .dir_i      (cpu_wdata_i[CTL_DIR_BIT]),
    .grant_i    (bus_grant_i),
    .drq_i      (drq_i),
    .cnt_zero_i (cnt_zero),
    .cnt_last_i (cnt_last),
    .run_o      (run),
    .done_o     (done),
    .dir_o      (dir),
    .bus_req_o  (bus_req_o),
    .beat_o     (beat)
  );

  dma_xfer_mux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mux (
    .beat_i      (beat),
    .dir_i       (dir),
    .addr_i      (addr_q),
    .per_data_i  (per_data_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .per_data_o  (per_data_o),
    .dack_o      (dack_o)
  );

  always_comb begin
    status               = '0;
    status[STS_RUN_BIT]  = run;
    status[STS_DIR_BIT]  = dir;
    status[STS_DONE_BIT] = done;
  end

  always_comb begin
    unique case (sel)
      SEL_ADDR:  rd_mux = DATA_W'(addr_q);
      SEL_COUNT: rd_mux = DATA_W'(cnt_q);
      SEL_CTRL:  rd_mux = DATA_W'(status);
      default:   rd_mux = '0;
    endcase
  end

  assign cpu_rdata_o = rd_en ? rd_mux : '0;
  assign done_o      = done;
  assign irq_o       = done;
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              cpu_wr_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              bus_req_o,
  input logic              bus_grant_i,
  input logic              drq_i,
  input logic              dack_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CNT_W-1:0]  cnt_q
);
  AST_REQ_NEEDS_WORK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (drq_i && cnt_q != '0)); // R4

  AST_DACK_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> (bus_grant_i && bus_req_o)); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o) && ((mem_rd_o || mem_wr_o) == dack_o)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |=> (addr_q == $past(addr_q) + 1'b1)); // R6

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6

  AST_DONE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o); // R7

  AST_HOLD_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_grant_i && !(cs_i && cpu_wr_i)) |=> ($stable(addr_q) && $stable(cnt_q))); // R8

  AST_NO_READ_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant_i |-> (cpu_rdata_o == '0)); // R3
endmodule

bind dma_ctrl dma_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_i        (cs_i),
  .cpu_wr_i    (cpu_wr_i),
  .cpu_rdata_o (cpu_rdata_o),
  .bus_req_o   (bus_req_o),
  .bus_grant_i (bus_grant_i),
  .drq_i       (drq_i),
  .dack_o      (dack_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .done_o      (done_o),
  .addr_q      (addr_q),
  .cnt_q       (cnt_q)
);

// File: tb/dma_ctrl_tb.sv
module dma_ctrl_tb;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 16;
  localparam int NVEC = 7;
  // {sel[1:0], wdata[15:0], expected readback[15:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 16'h1234, 16'h1234},
    {2'd1, 16'h0005, 16'h0005},
    {2'd0, 16'hFFFF, 16'hFFFF},
    {2'd1, 16'h0000, 16'h0000},
    {2'd2, 16'h0002, 16'h0002},
    {2'd2, 16'h0000, 16'h0000},
    {2'd3, 16'h7777, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0;
  logic [1:0]    sel = '0;
  logic          rd = 1'b0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          bus_req;
  logic          grant = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic          mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          drq = 1'b0;
  logic          dack;
  logic [DW-1:0] per_in = '0;
  logic [DW-1:0] per_out;
  logic          done;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_ctrl #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .reg_sel_i(sel),
    .cpu_rd_i(rd), .cpu_wr_i(wr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .bus_req_o(bus_req), .bus_grant_i(grant), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .drq_i(drq), .dack_o(dack),
    .per_data_i(per_in), .per_data_o(per_out), .done_o(done), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cpu_write(input logic [1:0] s, input logic [DW-1:0] d);
    cs = 1'b1; wr = 1'b1; sel = s; wdata = d;
    tick();
    cs = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic cpu_read(input logic [1:0] s, input logic [DW-1:0] exp, input string req);
    cs = 1'b1; rd = 1'b1; sel = s;
    #1;
    check(req, 32'(rdata), 32'(exp));
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    cpu_read(2'd0, 16'h0000, "R1 addr");
    cpu_read(2'd1, 16'h0000, "R1 count");
    cpu_read(2'd2, 16'h0000, "R1 ctrl");
    check("R1 bus_req", 32'(bus_req), 0);
    check("R1 dack", 32'(dack), 0);
    check("R1 done", 32'(done), 0);
    check("R1 irq", 32'(irq), 0);

    // R2 register table
    for (int i = 0; i < NVEC; i++) begin
      cpu_write(VEC[i][33:32], VEC[i][31:16]);
      cpu_read(VEC[i][33:32], VEC[i][15:0], "R2 table");
    end

    // program a 3-word peripheral-to-memory job
    cpu_write(2'd0, 16'h0100);
    cpu_write(2'd1, 16'h0003);
    cpu_write(2'd2, 16'h0001);
    #1;
    check("R4 no drq no req", 32'(bus_req), 0);
    check("R4 no drq no dack", 32'(dack), 0);
    drq = 1'b1;
    #1;
    check("R4 req raised", 32'(bus_req), 1);
    check("R5 no dack without grant", 32'(dack), 0);
    per_in = 16'hBEEF;
    grant = 1'b1;
    #1;
    check("R5 dack", 32'(dack), 1);
    check("R5 mem_wr", 32'(mem_wr), 1);
    check("R5 mem_rd low", 32'(mem_rd), 0);
    check("R5 mem_addr", 32'(mem_addr), 32'h0100);
    check("R5 mem_wdata", 32'(mem_wdata), 32'hBEEF);
    tick();
    grant = 1'b0;
    #1;
    check("R5 no strobe without grant", 32'(mem_wr), 0);
    repeat (3) tick();
    cpu_read(2'd0, 16'h0101, "R6 R8 addr held");
    cpu_read(2'd1, 16'h0002, "R6 R8 count held");

    // R3 access ignored while granted
    drq = 1'b0;
    grant = 1'b1;
    cs = 1'b1; rd = 1'b1; sel = 2'd0;
    #1;
    check("R3 rdata zero granted", 32'(rdata), 0);
    cs = 1'b0; rd = 1'b0;
    cpu_write(2'd0, 16'hAAAA);
    cpu_write(2'd1, 16'h0009);
    grant = 1'b0;
    cpu_read(2'd0, 16'h0101, "R3 addr unchanged");
    cpu_read(2'd1, 16'h0002, "R3 count unchanged");

    // resume and finish
    drq = 1'b1;
    grant = 1'b1;
    #1;
    check("R8 resume addr", 32'(mem_addr), 32'h0101);
    tick();
    check("R6 next addr", 32'(mem_addr), 32'h0102);
    check("R7 not done yet", 32'(done), 0);
    tick();
    check("R7 done", 32'(done), 1);
    check("R7 irq", 32'(irq), 1);
    check("R7 req dropped", 32'(bus_req), 0);
    check("R7 dack low", 32'(dack), 0);
    grant = 1'b0;
    cpu_read(2'd2, 16'h0004, "R7 ctrl done no run");
    cpu_read(2'd0, 16'h0103, "R6 final addr");
    cpu_read(2'd1, 16'h0000, "R7 final count");

    // R9 restart memory-to-peripheral
    cpu_write(2'd0, 16'h0200);
    cpu_write(2'd1, 16'h0002);
    cpu_write(2'd2, 16'h0003);
    check("R9 done cleared", 32'(done), 0);
    check("R9 irq cleared", 32'(irq), 0);
    mem_rdata = 16'h5A5A;
    grant = 1'b1;
    #1;
    check("R5 dir1 mem_rd", 32'(mem_rd), 1);
    check("R5 dir1 mem_wr low", 32'(mem_wr), 0);
    check("R5 dir1 per_data", 32'(per_out), 32'h5A5A);
    check("R5 dir1 addr", 32'(mem_addr), 32'h0200);
    drq = 1'b0;
    #1;
    check("R4 drq low no dack", 32'(dack), 0);
    check("R4 drq low no mem_rd", 32'(mem_rd), 0);
    drq = 1'b1;
    tick();
    tick();
    check("R7 dir1 done", 32'(done), 1);
    grant = 1'b0;

    // R10 zero-length start
    cpu_write(2'd1, 16'h0000);
    cpu_write(2'd2, 16'h0001);
    check("R10 done at once", 32'(done), 1);
    check("R10 no req", 32'(bus_req), 0);
    cpu_read(2'd2, 16'h0004, "R10 ctrl");

    drq = 1'b0;
    tick();
    finish_run();
  end
endmodule